// File: doc/BRIEF.md
# Quadrature and Pulse/Direction Position Decoder

This block turns the two phase inputs and the index input of one encoder channel into single-cycle count-up and count-down strobes for an external position counter. A two-bit mode input chooses how the phase inputs are read. Mode 0 is step/direction: each rising edge of A is a step, and B gives the direction. Modes 1, 2 and 3 read A and B as quadrature signals at one, two or four counts per full cycle. All three asynchronous pins pass through a chain of synchronising flops before any edge is examined.

Alongside the strobes the block keeps a direction flag and a sticky noise flag. The noise flag is set when both phase inputs change between two samples in a quadrature mode. The index input can be read at either polarity. In the quadrature modes it can also be gated so that it only counts when both phases are high. Each qualified index edge gives an index event and, when enabled, a preset-load request for the counter. The synchronised index level is also brought out.

Top module: `quad_decoder`

## Requirements
- R1: With mode = 0 (step/direction), each rising edge of A gives one strobe: cnt_up when B is 1 after the edge, cnt_dn when B is 0. Falling edges of A and any change of B alone give no strobe, and no noise is ever flagged in this mode.
- R2: With mode = 1 (x1), the quadrature phase order 00→10→11→01→00 (written as the bits A,B) is forward. A single strobe is given per full cycle: cnt_up on a rising edge of A while B is 0, and cnt_dn on a falling edge of A while B is 0.
- R3: With mode = 2 (x2), every single-input edge of A is one strobe, up when the step is forward and down when it is backward. Edges of B alone give nothing.
- R4: With mode = 3 (x4), every single-input edge of A or of B is one strobe, up for a forward step and down for a backward step.
- R5: dir_up is 0 after reset. It takes the value 1 at each up strobe and 0 at each down strobe, and otherwise keeps its value. cnt_up and cnt_dn are never high together.
- R6: While count_en is 0, no strobe is given and dir_up holds its value.
- R7: In modes 1 to 3, a change of both A and B between two synchronised samples gives no strobe and sets noise_err. noise_err stays set until a cycle in which noise_clr is 1 and no new clash is seen; a clash in the same cycle as noise_clr leaves noise_err set.
- R8: When idx_pol is 1, idx_event pulses for one cycle after the index goes from 0 to 1. When idx_pol is 0, it pulses after the index goes from 1 to 0. The opposite edge gives nothing. idx_level shows the synchronised index level without any polarity applied.
- R9: preset_load pulses in the same cycle as idx_event, and only when idx_preset_en is 1.
- R10: With idx_sync_req = 1 in modes 1 to 3, the index counts as active only while A and B are both 1. An event therefore fires when the last of the index, A and B reaches its active level. In mode 0, idx_sync_req has no effect.
- R11: An input change set up before rising clock edge k gives its strobe or event in the cycle after edge k+2, lasting one cycle.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_a | input | 1 | Phase A (or step) input, asynchronous |
| pin_b | input | 1 | Phase B (or direction) input, asynchronous |
| pin_idx | input | 1 | Index input, asynchronous |
| mode | input | 2 | 0 step/direction, 1 x1, 2 x2, 3 x4 |
| count_en | input | 1 | Enables strobes |
| idx_sync_req | input | 1 | Requests gating of the index by A and B high |
| idx_pol | input | 1 | Index active level: 1 high, 0 low |
| idx_preset_en | input | 1 | Turns index events into preset loads |
| noise_clr | input | 1 | Clears the noise flag |
| cnt_up | output | 1 | One-cycle count-up strobe |
| cnt_dn | output | 1 | One-cycle count-down strobe |
| dir_up | output | 1 | Direction of the last strobe |
| noise_err | output | 1 | Sticky illegal-transition flag |
| idx_event | output | 1 | One-cycle qualified index event |
| preset_load | output | 1 | One-cycle preset-load request |
| idx_level | output | 1 | Synchronised raw index level |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a noise clash and a clear. The bench drives a diagonal A/B change and raises noise_clr exactly in the cycle where the clash reaches the flag. The flag must remain set, and a later clear on its own must drop it. The second pair is a count strobe and an index event. The bench moves A and the index at the same clock edge and requires cnt_dn, idx_event and preset_load all high in the same sampled cycle. This comes on top of a sweep over every mode, every start phase and every next phase, with the expected counts and noise derived from phase arithmetic.

// File: rtl/enc_pkg.sv
// Shared definitions for the encoder decoder.
// Assumes: a 2-bit mode code, fixed by the register layout that feeds it.
package enc_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_STEP = 2'd0,
        MODE_X1   = 2'd1,
        MODE_X2   = 2'd2,
        MODE_X4   = 2'd3
    } enc_mode_e;
endpackage

// File: rtl/enc_sync.sv
// Multi-flop synchroniser for a bundle of asynchronous levels.
// Assumes: each bit is an independent slow level; the bits are not
// guaranteed to arrive on the same cycle relative to each other.
module enc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First flop samples the asynchronous pins
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_chain
            // Each later flop resamples the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/enc_step.sv
// Phase decoder: turns synchronised A/B levels into up/down strobes,
// a direction flag and a sticky noise flag.
// Assumes: a_s/b_s are synchronised; mode and count_en are quasi-static.
module enc_step
    import enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a_s,
    input  logic      b_s,
    input  enc_mode_e mode,
    input  logic      count_en,
    input  logic      noise_clr,
    output logic      cnt_up,
    output logic      cnt_dn,
    output logic      dir_up,
    output logic      noise_err
);
    logic a_p, b_p;
    logic edge_a, edge_b, clash;
    logic hit, go_up, fire;

    // Hold the previous sample of each phase for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_p <= 1'b0;
            b_p <= 1'b0;
        end else begin
            a_p <= a_s;
            b_p <= b_s;
        end
    end

    // Decide whether this sample is a count and which way it goes
    always_comb begin
        edge_a = a_s ^ a_p;
        edge_b = b_s ^ b_p;
        clash  = (mode != MODE_STEP) && edge_a && edge_b;
        hit    = 1'b0;
        go_up  = 1'b0;
        unique case (mode)
            MODE_STEP: begin
                hit   = edge_a && a_s;
                go_up = b_s;
            end
            MODE_X1: begin
                hit   = edge_a && !edge_b && !b_s;
                go_up = a_s;
            end
            MODE_X2: begin
                hit   = edge_a && !edge_b;
                go_up = a_s ^ b_s;
            end
            MODE_X4: begin
                hit   = edge_a ^ edge_b;
                go_up = edge_a ? (a_s ^ b_s) : !(a_s ^ b_s);
            end
            default: begin
                hit   = 1'b0;
                go_up = 1'b0;
            end
        endcase
        fire = hit && count_en;
    end

    // Register strobes and track direction of the last count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_up <= 1'b0;
            cnt_dn <= 1'b0;
            dir_up <= 1'b0;
        end else begin
            cnt_up <= fire && go_up;
            cnt_dn <= fire && !go_up;
            if (fire) dir_up <= go_up;
        end
    end

    // Sticky noise flag; a new clash outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n)         noise_err <= 1'b0;
        else if (clash)     noise_err <= 1'b1;
        else if (noise_clr) noise_err <= 1'b0;
    end

    assert_no_dual_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up && cnt_dn));
    assert_dir_up_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_up |-> dir_up);
    assert_dir_dn_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dn |-> !dir_up);
    assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(count_en) |-> !(cnt_up || cnt_dn));
    assert_noise_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_err && !noise_clr) |=> noise_err);
    assert_step_no_noise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_STEP && !$past(noise_err)) |-> !noise_err);
endmodule

// File: rtl/enc_index.sv
// Index qualifier: applies polarity and optional A/B gating, then turns
// the qualified level's rising edge into an event and a preset request.
// Assumes: idx_s, a_s, b_s are synchronised and on the same stage.
module enc_index
    import enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idx_s,
    input  logic      a_s,
    input  logic      b_s,
    input  enc_mode_e mode,
    input  logic      sync_req,
    input  logic      pol,
    input  logic      preset_en,
    output logic      idx_event,
    output logic      preset_load
);
    logic active, sync_on, gated, gated_p, rise;

    // Qualify the index; gating is only legal in the quadrature modes
    always_comb begin
        active  = pol ? idx_s : !idx_s;
        sync_on = sync_req && (mode != MODE_STEP);
        gated   = active && (!sync_on || (a_s && b_s));
        rise    = gated && !gated_p;
    end

    // Previous qualified level; starts high so reset gives no event
    always_ff @(posedge clk) begin
        if (!rst_n) gated_p <= 1'b1;
        else        gated_p <= gated;
    end

    // Register the event and the optional preset request together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_event   <= 1'b0;
            preset_load <= 1'b0;
        end else begin
            idx_event   <= rise;
            preset_load <= rise && preset_en;
        end
    end

    assert_event_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_event |=> !idx_event);
    assert_preset_with_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        preset_load |-> idx_event);
    assert_sync_needs_ab_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_event && $past(sync_req) && $past(mode) != MODE_STEP) |-> ($past(a_s) && $past(b_s)));
endmodule

// File: rtl/quad_decoder.sv
// Encoder channel front end: synchronises A, B and index, then decodes
// counts, direction, noise and index events for an external counter.
// Assumes: configuration inputs come from registers in this clock domain.
module quad_decoder
    import enc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              pin_idx,
    input  logic [MODE_W-1:0] mode,
    input  logic              count_en,
    input  logic              idx_sync_req,
    input  logic              idx_pol,
    input  logic              idx_preset_en,
    input  logic              noise_clr,
    output logic              cnt_up,
    output logic              cnt_dn,
    output logic              dir_up,
    output logic              noise_err,
    output logic              idx_event,
    output logic              preset_load,
    output logic              idx_level
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic             a_s, b_s, idx_s;
    enc_mode_e        mode_e;

    assign mode_e = enc_mode_e'(mode);

    enc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pin_idx, pin_b, pin_a}),
        .q     (pins_s)
    );

    assign a_s       = pins_s[0];
    assign b_s       = pins_s[1];
    assign idx_s     = pins_s[2];
    assign idx_level = idx_s;

    enc_step u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_s       (a_s),
        .b_s       (b_s),
        .mode      (mode_e),
        .count_en  (count_en),
        .noise_clr (noise_clr),
        .cnt_up    (cnt_up),
        .cnt_dn    (cnt_dn),
        .dir_up    (dir_up),
        .noise_err (noise_err)
    );

    enc_index u_index (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_s       (idx_s),
        .a_s         (a_s),
        .b_s         (b_s),
        .mode        (mode_e),
        .sync_req    (idx_sync_req),
        .pol         (idx_pol),
        .preset_en   (idx_preset_en),
        .idx_event   (idx_event),
        .preset_load (preset_load)
    );
endmodule

// File: tb/sim_quad_decoder.sv
module sim_quad_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_a = 1'b0, pin_b = 1'b0, pin_idx = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       count_en = 1'b1, idx_sync_req = 1'b0, idx_pol = 1'b1;
    logic       idx_preset_en = 1'b1, noise_clr = 1'b0;
    logic       cnt_up, cnt_dn, dir_up, noise_err, idx_event, preset_load, idx_level;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int up_tot = 0, dn_tot = 0, ev_tot = 0, pl_tot = 0;
    bit exp_dir = 1'b0, exp_noise = 1'b0;

    always #10 clk = ~clk;

    quad_decoder u0 (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_idx(pin_idx),
        .mode(mode), .count_en(count_en), .idx_sync_req(idx_sync_req),
        .idx_pol(idx_pol), .idx_preset_en(idx_preset_en), .noise_clr(noise_clr),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn), .dir_up(dir_up), .noise_err(noise_err),
        .idx_event(idx_event), .preset_load(preset_load), .idx_level(idx_level)
    );

    // Tally output pulses away from the active edge
    always @(negedge clk) begin
        if (cnt_up)      up_tot <= up_tot + 1;
        if (cnt_dn)      dn_tot <= dn_tot + 1;
        if (idx_event)   ev_tot <= ev_tot + 1;
        if (preset_load) pl_tot <= pl_tot + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int phase(input bit a, input bit b);
        return b ? (a ? 2 : 3) : (a ? 1 : 0);
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Apply one A/B change and check strobes, direction and noise
    task automatic step(input bit na, input bit nb);
        bit oa, ob, hit, up, clash;
        int d, u0c, d0c;
        string req;
        oa = pin_a; ob = pin_b;
        if (oa == na && ob == nb) return;
        d = (phase(na, nb) - phase(oa, ob)) & 3;
        hit = 0; up = 0; clash = 0;
        if (mode == 2'd0) begin
            hit = !oa && na; up = nb;
        end else if (d == 2) begin
            clash = 1;
        end else begin
            up = (d == 1);
            case (mode)
                2'd1: hit = (oa != na) && !nb;
                2'd2: hit = (oa != na);
                default: hit = 1;
            endcase
        end
        req = (mode == 2'd0) ? "R1" : (mode == 2'd1) ? "R2" : (mode == 2'd2) ? "R3" : "R4";
        if (!count_en) begin hit = 0; req = "R6"; end
        if (clash) exp_noise = 1;
        if (hit) exp_dir = up;
        @(negedge clk);
        u0c = up_tot; d0c = dn_tot;
        pin_a = na; pin_b = nb;
        settle();
        chk(req, "up strobes", up_tot - u0c, (hit && up) ? 1 : 0);
        chk(req, "down strobes", dn_tot - d0c, (hit && !up) ? 1 : 0);
        chk(count_en ? "R5" : "R6", "dir_up", dir_up, exp_dir);
        chk("R7", "noise_err", noise_err, exp_noise);
    endtask

    task automatic go_to(input int st);
        bit ta, tb;
        ta = (st == 1 || st == 2);
        tb = (st >= 2);
        step(ta, pin_b);
        step(ta, tb);
    endtask

    task automatic clear_noise();
        @(negedge clk); noise_clr = 1;
        @(negedge clk); noise_clr = 0;
        exp_noise = 0;
    endtask

    task automatic idx_drive(input bit v, input string req, input int exp_ev, input int exp_pl);
        int e0, p0;
        @(negedge clk);
        e0 = ev_tot; p0 = pl_tot;
        pin_idx = v;
        settle();
        chk(req, "index events", ev_tot - e0, exp_ev);
        chk("R9", "preset loads", pl_tot - p0, exp_pl);
        chk("R8", "idx_level", idx_level, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog expired: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int e0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "cnt_up", cnt_up, 0);
        chk("R12", "cnt_dn", cnt_dn, 0);
        chk("R12", "dir_up", dir_up, 0);
        chk("R12", "noise_err", noise_err, 0);
        chk("R12", "idx_event", idx_event, 0);
        chk("R12", "preset_load", preset_load, 0);
        chk("R12", "idx_level", idx_level, 0);

        // R1-R4 sweep: every mode, start phase and target phase
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            for (int o = 0; o < 4; o++) begin
                for (int t = 0; t < 4; t++) begin
                    if (t == o) continue;
                    go_to(o);
                    clear_noise();
                    step(t == 1 || t == 2, t >= 2);
                end
            end
        end
        clear_noise();

        // R2: full forward and backward cycles in x1
        mode = 2'd1; go_to(0);
        for (int k = 0; k < 8; k++) go_to((k + 1) % 4);
        for (int k = 0; k < 8; k++) go_to((7 - k) % 4);

        // R6: counting disabled in x4
        mode = 2'd3; count_en = 0;
        for (int k = 0; k < 4; k++) go_to((k + 1) % 4);
        count_en = 1;

        // R7: clash and clear in the same cycle; clash must win
        go_to(0); clear_noise();
        @(negedge clk); pin_a = 1; pin_b = 1;
        @(negedge clk);
        @(negedge clk); noise_clr = 1;
        @(negedge clk); noise_clr = 0;
        chk("R7", "noise set beats clear", noise_err, 1);
        @(negedge clk); noise_clr = 1;
        @(negedge clk); noise_clr = 0;
        chk("R7", "noise cleared", noise_err, 0);
        exp_noise = 0;

        // R11: latency of a strobe, state 11 -> 01 is forward in x4
        @(negedge clk); pin_a = 0;
        @(negedge clk); chk("R11", "cnt_up n1", cnt_up, 0);
        @(negedge clk); chk("R11", "cnt_up n2", cnt_up, 0);
        @(negedge clk); chk("R11", "cnt_up n3", cnt_up, 1);
        @(negedge clk); chk("R11", "cnt_up n4", cnt_up, 0);
        exp_dir = 1;

        // Count and index event in the same cycle (01 -> 11 backward)
        idx_pol = 1; idx_preset_en = 1; idx_sync_req = 0;
        @(negedge clk); pin_a = 1; pin_idx = 1;
        @(negedge clk); @(negedge clk);
        @(negedge clk);
        chk("R4", "cnt_dn with index", cnt_dn, 1);
        chk("R8", "idx_event with count", idx_event, 1);
        chk("R9", "preset_load with count", preset_load, 1);
        exp_dir = 0;
        settle();

        // R8/R9: polarity and preset enable
        idx_drive(0, "R8", 0, 0);
        idx_preset_en = 0;
        idx_drive(1, "R8", 1, 0);
        idx_pol = 0;
        repeat (3) @(negedge clk);
        idx_drive(0, "R8", 1, 0);
        idx_pol = 1;
        repeat (3) @(negedge clk);

        // R10: synchronous index waits for A and B both high in x4
        idx_preset_en = 1; idx_sync_req = 1; mode = 2'd3;
        go_to(0);
        idx_drive(1, "R10", 0, 0);
        e0 = ev_tot;
        go_to(1);
        chk("R10", "no event at A high only", ev_tot - e0, 0);
        go_to(2);
        chk("R10", "event when A and B high", ev_tot - e0, 1);

        // R10: request ignored in step/direction mode
        idx_drive(0, "R10", 0, 0);
        mode = 2'd0;
        go_to(0);
        idx_drive(1, "R10", 1, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule